// File: doc/BRIEF.md
# Debounced Matrix Keyboard Scanner

This block scans a five-by-five key matrix. It drives one row output high at a time. While a row is driven, it reads the five column inputs. Each full scan is made of seven equal time slots. The first five slots each drive one row. The last two slots leave every row low as idle time. The column inputs pass through a two-stage synchronizer. The scanner samples them on the last clock of each row slot. At the end of the scan, the result is held as a 25-bit picture of the matrix.

A picture becomes the accepted one only after the same picture has been seen on a set number of scans in a row. By default this number is 256 scans, with slots of 512 clocks. Any scan that differs starts the run count again, and the differing scan is the first of the new run. The accepted picture is reduced to a key code. A picture with exactly one bit set gives a valid key with its row and column index. Any other picture means no key. When the accepted code differs from the one being reported, the outputs take the new code and a one-cycle interrupt pulse is raised in the same cycle. Only one key at a time is supported. Ghosting is not resolved.

An enable input starts and stops scanning. While it is low, the rows stay low and the reported code is held.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all row outputs are low, key_valid_o is 0, key_row_o and key_col_o are 0 and irq_o is 0.
- R2: Scanning starts in the cycle after enable is first seen high. Slot s lasts SLOT_CLKS cycles. In slots 0 to 4, row_o is one-hot with bit s set. In slots 5 and 6, row_o is all zero. After slot 6 the sequence repeats from slot 0, and at no time is more than one row high.
- R3: If the only closed key connects row r (row_o bit r) to column c (col_i bit c), then once that picture is accepted key_valid_o is 1, key_row_o equals r and key_col_o equals c.
- R4: If the accepted picture has no bit set, or more than one bit set (in the same row or in different rows), key_valid_o is 0 and key_row_o and key_col_o are 0.
- R5: irq_o is a pulse of one cycle. It is raised exactly in the cycle in which key_valid_o, key_row_o or key_col_o changes, and never at any other time.
- R6: A new picture is accepted only after STABLE_SCANS consecutive scans produce it. A scan that differs restarts the run count. Input that keeps changing in runs shorter than STABLE_SCANS scans causes no interrupt. A steady change is reported no sooner than (STABLE_SCANS-1) scan lengths after it is applied.
- R7: While en_i is low, all rows are low from the next cycle, no new picture is taken and the key outputs keep their values. When en_i returns high, scanning restarts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Scan enable |
| col_i | input | 5 | Column inputs, asynchronous |
| row_o | output | 5 | Row drive, active high |
| key_valid_o | output | 1 | A single key is reported |
| key_row_o | output | 3 | Row index of the reported key |
| key_col_o | output | 3 | Column index of the reported key |
| irq_o | output | 1 | One-cycle pulse when the reported key state changes |

## Verification
A slot counter or slot decode that goes wrong shows at the row outputs within one slot. It appears as a doubled row, a missing idle slot or a slot of the wrong length. An error in the run counter or the candidate register shows up within one debounce window. The interrupt then comes too early, comes during bouncing input, or never comes. A fault in the row/column mapping or the picture reduction shows as a wrong code at the first accepted press. The exhaustive sweep over all 25 keys exposes it there. Errors in the change detection show as a missing pulse, a doubled pulse, or outputs that change with no pulse.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    localparam int unsigned KBD_ROWS  = 5;
    localparam int unsigned KBD_COLS  = 5;
    localparam int unsigned KBD_SLOTS = 7;
    localparam int unsigned KBD_KEYS  = KBD_ROWS * KBD_COLS;
    localparam int unsigned ROW_W     = $clog2(KBD_ROWS);
    localparam int unsigned COL_W     = $clog2(KBD_COLS);
    localparam int unsigned SLOT_W    = $clog2(KBD_SLOTS);

    typedef logic [KBD_KEYS-1:0] scan_vec_t;

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } key_code_t;

    // Bit r*KBD_COLS+c of the picture is the key at row r, column c.
    // Exactly one bit set gives a valid code; anything else gives no key.
    function automatic key_code_t decode_scan(scan_vec_t pic);
        key_code_t   k;
        int unsigned ones;
        k    = '0;
        ones = 0;
        for (int r = KBD_ROWS - 1; r >= 0; r--) begin
            for (int c = KBD_COLS - 1; c >= 0; c--) begin
                if (pic[r*KBD_COLS + c]) begin
                    ones  = ones + 1;
                    k.row = ROW_W'(r);
                    k.col = COL_W'(c);
                end
            end
        end
        if (ones == 1) begin
            k.valid = 1'b1;
        end else begin
            k = '0;
        end
        return k;
    endfunction

endpackage

// File: rtl/kbd_col_sync.sv
module kbd_col_sync
    import kbd_pkg::*;
#(
    parameter int unsigned WIDTH = KBD_COLS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/kbd_scan_timer.sv
module kbd_scan_timer
    import kbd_pkg::*;
#(
    parameter int unsigned SLOT_CLKS = 512,
    localparam int unsigned CNT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    output logic [KBD_ROWS-1:0] row_o,
    output logic [SLOT_W-1:0]   slot_o,
    output logic                sample_o,
    output logic                done_o
);

    localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(SLOT_CLKS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(KBD_SLOTS - 1);
    localparam logic [SLOT_W-1:0] ROW_SLOTS = SLOT_W'(KBD_ROWS);

    logic              run_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic              slot_end;

    assign slot_end = run_q && (cnt_q == LAST_CNT);

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            slot_q <= '0;
        end else begin
            run_q <= 1'b1;
            if (run_q) begin
                if (slot_end) begin
                    cnt_q  <= '0;
                    slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    for (genvar r = 0; r < KBD_ROWS; r++) begin : g_row
        assign row_o[r] = run_q && (slot_q == SLOT_W'(r));
    end

    assign slot_o   = slot_q;
    assign sample_o = slot_end && (slot_q < ROW_SLOTS);
    assign done_o   = slot_end && (slot_q == LAST_SLOT);

endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce
    import kbd_pkg::*;
#(
    parameter int unsigned STABLE_SCANS = 256,
    localparam int unsigned RUN_W = $clog2(STABLE_SCANS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                sample_i,
    input  logic [SLOT_W-1:0]   slot_i,
    input  logic                done_i,
    input  logic [KBD_COLS-1:0] col_i,
    output key_code_t           key_o,
    output logic                irq_o
);

    localparam logic [RUN_W-1:0] RUN_TARGET = RUN_W'(STABLE_SCANS);

    scan_vec_t        pic_q;
    scan_vec_t        cand_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_next;
    key_code_t        key_q;
    key_code_t        key_new;
    logic             irq_q;

    // Row slots fill their own field of the picture as they end.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pic_q <= '0;
        end else if (sample_i) begin
            for (int r = 0; r < KBD_ROWS; r++) begin
                if (slot_i == SLOT_W'(r)) begin
                    pic_q[r*KBD_COLS +: KBD_COLS] <= col_i;
                end
            end
        end
    end

    always_comb begin
        if (pic_q == cand_q) begin
            run_next = (run_q == RUN_TARGET) ? run_q : run_q + 1'b1;
        end else begin
            run_next = RUN_W'(1);
        end
        key_new = decode_scan(pic_q);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cand_q <= '0;
            run_q  <= '0;
            key_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (done_i) begin
                cand_q <= pic_q;
                run_q  <= run_next;
                if ((run_next == RUN_TARGET) && (key_new != key_q)) begin
                    key_q <= key_new;
                    irq_q <= 1'b1;
                end
            end
        end
    end

    assign key_o = key_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
    import kbd_pkg::*;
#(
    parameter int unsigned SLOT_CLKS    = 512,
    parameter int unsigned STABLE_SCANS = 256
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    input  logic [KBD_COLS-1:0] col_i,
    output logic [KBD_ROWS-1:0] row_o,
    output logic                key_valid_o,
    output logic [ROW_W-1:0]    key_row_o,
    output logic [COL_W-1:0]    key_col_o,
    output logic                irq_o
);

    logic [SLOT_W-1:0]   slot;
    logic                sample;
    logic                done;
    logic [KBD_COLS-1:0] col_sync;
    key_code_t           key;

    kbd_scan_timer #(
        .SLOT_CLKS(SLOT_CLKS)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .row_o   (row_o),
        .slot_o  (slot),
        .sample_o(sample),
        .done_o  (done)
    );

    kbd_col_sync #(
        .WIDTH(KBD_COLS)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i(col_i),
        .sync_o (col_sync)
    );

    kbd_debounce #(
        .STABLE_SCANS(STABLE_SCANS)
    ) u_debounce (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .sample_i(sample),
        .slot_i  (slot),
        .done_i  (done),
        .col_i   (col_sync),
        .key_o   (key),
        .irq_o   (irq_o)
    );

    assign key_valid_o = key.valid;
    assign key_row_o   = key.row;
    assign key_col_o   = key.col;

endmodule

// File: rtl/kbd_scanner_chk.sv
module kbd_scanner_chk
    import kbd_pkg::*;
(
    input logic                clk_i,
    input logic                rst_i,
    input logic                en_i,
    input logic [KBD_ROWS-1:0] row_o,
    input logic                key_valid_o,
    input logic [ROW_W-1:0]    key_row_o,
    input logic [COL_W-1:0]    key_col_o,
    input logic                irq_o
);

    AST_ROWS_ONEHOT0: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(row_o));                                                   // R2

    AST_ROWS_OFF_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (row_o == '0));                                           // R7

    AST_NO_KEY_ZERO_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
        !key_valid_o |-> (key_row_o == '0 && key_col_o == '0));             // R4

    AST_ROW_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        key_valid_o |-> (key_row_o < ROW_W'(KBD_ROWS)));                    // R3

    AST_COL_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        key_valid_o |-> (key_col_o < COL_W'(KBD_COLS)));                    // R3

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> !irq_o);                                                  // R5

    AST_CODE_CHANGE_HAS_IRQ: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable({key_valid_o, key_row_o, key_col_o}) |-> irq_o);           // R5

    AST_IRQ_HAS_CODE_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> !$stable({key_valid_o, key_row_o, key_col_o}));           // R5

endmodule

bind kbd_matrix_scanner kbd_scanner_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .row_o      (row_o),
    .key_valid_o(key_valid_o),
    .key_row_o  (key_row_o),
    .key_col_o  (key_col_o),
    .irq_o      (irq_o)
);

// File: tb/tb_kbd_matrix_scanner.sv
module tb_kbd_matrix_scanner;
    import kbd_pkg::*;

    localparam int SLOT  = 4;
    localparam int NSTAB = 4;
    localparam int SCAN  = SLOT * 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [4:0] col;
    logic [4:0] row;
    logic       kv;
    logic [2:0] krow;
    logic [2:0] kcol;
    logic       irq;
    logic [24:0] pressed = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Matrix model: column c goes high when a driven row has key (r,c) closed.
    always_comb begin
        col = '0;
        for (int r = 0; r < 5; r++)
            for (int c = 0; c < 5; c++)
                if (row[r] && pressed[r*5 + c]) col[c] = 1'b1;
    end

    kbd_matrix_scanner #(.SLOT_CLKS(SLOT), .STABLE_SCANS(NSTAB)) dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .col_i(col), .row_o(row),
        .key_valid_o(kv), .key_row_o(krow), .key_col_o(kcol), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_irq(input int limit, output int waited, output bit seen);
        seen = 0;
        waited = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            waited = i;
            if (irq) begin
                seen = 1;
                return;
            end
        end
    endtask

    task automatic check_rows(input int ncyc, input string req);
        for (int k = 0; k < ncyc; k++) begin
            int slot;
            int exp;
            @(negedge clk);
            slot = (k / SLOT) % 7;
            exp  = (slot < 5) ? (1 << slot) : 0;
            chk(row == 5'(exp), req, "row_o pattern", int'(row), exp);
        end
    endtask

    task automatic expect_key(input int r, input int c, input string req);
        int  w;
        bit  s;
        wait_irq((NSTAB + 2) * SCAN, w, s);
        chk(s, req, "irq on press", int'(s), 1);
        chk(w >= (NSTAB - 1) * SCAN, "R6", "press latency lower bound", w, (NSTAB - 1) * SCAN);
        chk(kv == 1'b1, req, "key_valid", int'(kv), 1);
        chk(krow == 3'(r), req, "key_row", int'(krow), r);
        chk(kcol == 3'(c), req, "key_col", int'(kcol), c);
        @(negedge clk);
        chk(irq == 1'b0, "R5", "irq width", int'(irq), 0);
    endtask

    task automatic expect_none(input string req);
        int w;
        bit s;
        wait_irq((NSTAB + 2) * SCAN, w, s);
        chk(s, req, "irq on release/multi", int'(s), 1);
        chk(kv == 1'b0, req, "key_valid", int'(kv), 0);
        chk(krow == 3'd0 && kcol == 3'd0, req, "code zero", int'({krow, kcol}), 0);
        @(negedge clk);
        chk(irq == 1'b0, "R5", "irq width", int'(irq), 0);
    endtask

    task automatic expect_quiet(input int ncyc, input string req);
        int hits = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (irq) hits++;
        end
        chk(hits == 0, req, "unexpected irq count", hits, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(row == 5'd0 && kv == 1'b0 && krow == 3'd0 && kcol == 3'd0 && irq == 1'b0,
            "R1", "outputs in reset", int'({row, kv, krow, kcol, irq}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(row == 5'd0 && kv == 1'b0 && irq == 1'b0, "R1", "outputs after reset",
            int'({row, kv, irq}), 0);

        // R2: row sequence over two scans
        en = 1'b1;
        check_rows(2 * SCAN, "R2");

        // R5: idle matrix gives no interrupt
        expect_quiet((NSTAB + 2) * SCAN, "R5");

        // R3/R4: exhaustive single-key sweep
        for (int r = 0; r < 5; r++) begin
            for (int c = 0; c < 5; c++) begin
                pressed = 25'(1) << (r*5 + c);
                expect_key(r, c, "R3");
                pressed = '0;
                expect_none("R4");
            end
        end

        // R4: two keys in different rows after a valid key
        pressed = 25'(1) << (1*5 + 1);
        expect_key(1, 1, "R3");
        pressed = pressed | (25'(1) << (3*5 + 4));
        expect_none("R4");
        // R4: two keys in one row; state stays no-key, so no interrupt
        pressed = (25'(1) << (2*5 + 0)) | (25'(1) << (2*5 + 4));
        expect_quiet((NSTAB + 3) * SCAN, "R4");
        chk(kv == 1'b0, "R4", "same-row pair key_valid", int'(kv), 0);
        pressed = '0;
        expect_quiet((NSTAB + 3) * SCAN, "R4");

        // R6: bouncing contact, runs shorter than NSTAB scans
        begin
            int hits = 0;
            for (int t = 0; t < 12; t++) begin
                pressed = (t % 2 == 0) ? (25'(1) << (4*5 + 2)) : '0;
                for (int i = 0; i < SCAN + SCAN / 2; i++) begin
                    @(negedge clk);
                    if (irq) hits++;
                end
            end
            chk(hits == 0, "R6", "irq during bounce", hits, 0);
        end
        pressed = 25'(1) << (4*5 + 2);
        expect_key(4, 2, "R6");
        pressed = '0;
        expect_none("R6");

        // R7: disable holds state and stops rows
        pressed = 25'(1) << (1*5 + 1);
        expect_key(1, 1, "R3");
        en = 1'b0;
        pressed = '0;
        begin
            int busy = 0;
            int hits = 0;
            for (int i = 0; i < 10 * SCAN; i++) begin
                @(negedge clk);
                if (row != 5'd0) busy++;
                if (irq) hits++;
            end
            chk(busy == 0, "R7", "rows high while disabled", busy, 0);
            chk(hits == 0, "R7", "irq while disabled", hits, 0);
            chk(kv == 1'b1 && krow == 3'd1 && kcol == 3'd1, "R7", "held code",
                int'({kv, krow, kcol}), int'({1'b1, 3'd1, 3'd1}));
        end
        en = 1'b1;
        check_rows(SCAN, "R7");
        expect_none("R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule